// File: doc/BRIEF.md
# FIFO Trigger-Level Interrupt Controller

This block sits between a host bus and the character engines of a serial port. It owns two byte queues of equal depth. The host fills the transmit queue and the transmitter drains it. The receiver fills the receive queue and the host drains it. An 8-bit control word, written by the host, does several things at once:

- switches the queues on;
- empties either queue on demand;
- selects a transfer mode flag that ready-pin logic elsewhere consumes;
- picks the occupancy thresholds used for service requests.

Two service requests come out of the block, and both are derived from queue occupancy. The receive request stays high while enough characters are waiting. The transmit request fires when the queue runs low after having been loaded past its threshold. If the last load never reached the threshold, it fires only once the queue is empty. A flush touches only the queue's pointers, count and error flags, so a character already handed to the transmitter is unaffected. Writes to the threshold fields are honoured only while an enhanced-feature enable input is high.

Top module: `fifo_trig_ctl`

## Requirements
- R1: After reset both counts are 0, both queues report empty, the transmit request is 1, the receive request is 0, the mode output is 0, and the control readback is 0x00.
- R2: Control bit 0 is the queue enable and reads back at bit 0. While it is 0, pushes to either queue are dropped and the count does not change.
- R3: Each queue holds up to 128 bytes. The head byte is visible on the pop-data output, and bytes leave in the order they entered. The count follows each accepted push and pop in the cycle after the edge that accepts it.
- R4: A control write with bits 0 and 2 both set empties the transmit queue: the count becomes 0 and its sticky flags clear. The receive queue is untouched. A write with bit 2 set and bit 0 clear empties nothing.
- R5: A control write with bits 0 and 1 both set empties the receive queue in the same way. The transmit queue is untouched.
- R6: The two flush bits (1 and 2) always read back as 0. The readback layout is bit 0 enable, bit 3 mode, bits 5:4 transmit threshold select, bits 7:6 receive threshold select, and bits 2:1 zero.
- R7: Control bit 3 sets the mode output (1 selects the DMA-style ready behaviour, 0 the normal one).
- R8: Bits 7:4 are stored only when the enhanced-feature enable input is 1 during the write. Otherwise the previous selects are kept, while bits 0 and 3 still update.
- R9: The receive request is 1 exactly while the receive count is at or above the selected level. The receive select codes 00, 01, 10 and 11 give levels 1, 16, 32 and 56.
- R10: The transmit select codes 00, 01, 10 and 11 give levels 1, 8, 16 and 32. If the count has reached the level since the queue was last empty, the request is 1 whenever the count is below the level. Otherwise the request is 1 only at count 0. It is 0 while the count is at or above the level.
- R11: A push to a full, enabled queue is dropped and sets that queue's sticky overflow flag. Only reset or that queue's flush clears the flag.
- R12: A pop from an empty queue is dropped and sets that queue's sticky underflow flag. Only reset or that queue's flush clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| feat_en | input | 1 | Enhanced-feature enable; gates threshold-select writes |
| cfg_rdata | output | 8 | Control word readback |
| dma_mode | output | 1 | Transfer mode flag for ready-pin logic |
| tx_push | input | 1 | Host write into the transmit queue |
| tx_push_data | input | 8 | Transmit byte to store |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_pop_data | output | 8 | Transmit head byte |
| tx_count | output | 8 | Transmit occupancy |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_req | output | 1 | Transmit service request |
| tx_ovf | output | 1 | Transmit sticky overflow |
| tx_udf | output | 1 | Transmit sticky underflow |
| rx_push | input | 1 | Receiver stores a byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads the head byte |
| rx_pop_data | output | 8 | Receive head byte |
| rx_count | output | 8 | Receive occupancy |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_req | output | 1 | Receive service request |
| rx_ovf | output | 1 | Receive sticky overflow |
| rx_udf | output | 1 | Receive sticky underflow |

## Verification
Every result is registered exactly once after its stimulus. A control write, push or pop applied before a rising edge is visible in the readback, the counts, the flags and both requests right after that edge. The head byte changes at that same edge. The bench drives each stimulus for one full cycle starting at a falling edge, and samples at the next falling edge, one cycle later. It reads each pop's expected byte from its scoreboard queue and compares it with the head output before the pop strobe is applied.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

    // Control word bit positions (the readback layout depends on them)
    localparam int unsigned BIT_EN       = 0;
    localparam int unsigned BIT_RX_FLUSH = 1;
    localparam int unsigned BIT_TX_FLUSH = 2;
    localparam int unsigned BIT_DMA      = 3;
    localparam int unsigned TX_SEL_LO    = 4;
    localparam int unsigned RX_SEL_LO    = 6;

    typedef struct packed {
        logic [1:0] rx_sel;
        logic [1:0] tx_sel;
        logic       dma;
        logic       en;
    } ftc_cfg_t;

    typedef enum logic {
        TXP_FILLING = 1'b0,
        TXP_ARMED   = 1'b1
    } tx_phase_e;

    function automatic int unsigned rx_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 16;
            2'b10:   return 32;
            default: return 56;
        endcase
    endfunction

    function automatic int unsigned tx_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 8;
            2'b10:   return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/ftc_ctrl_reg.sv
module ftc_ctrl_reg
    import ftc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       feat_en,
    output ftc_cfg_t   cfg,
    output logic       tx_flush,
    output logic       rx_flush,
    output logic [7:0] rdata
);

    // Flush commands are never stored: they act on the write edge only
    assign tx_flush = we & wdata[BIT_EN] & wdata[BIT_TX_FLUSH];
    assign rx_flush = we & wdata[BIT_EN] & wdata[BIT_RX_FLUSH];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg.en  <= wdata[BIT_EN];
            cfg.dma <= wdata[BIT_DMA];
            if (feat_en) begin
                cfg.tx_sel <= wdata[TX_SEL_LO +: 2];
                cfg.rx_sel <= wdata[RX_SEL_LO +: 2];
            end
        end
    end

    always_comb begin
        rdata                  = '0;
        rdata[BIT_EN]          = cfg.en;
        rdata[BIT_DMA]         = cfg.dma;
        rdata[TX_SEL_LO +: 2]  = cfg.tx_sel;
        rdata[RX_SEL_LO +: 2]  = cfg.rx_sel;
    end

endmodule

// File: rtl/ftc_byte_fifo.sv
module ftc_byte_fifo #(
    parameter  int DEPTH = 128,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          en,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ovf,
    output logic          udf
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign push_ok  = en & push & ~full & ~flush;
    assign pop_ok   = pop & ~empty & ~flush;
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ovf <= 1'b0;
            udf <= 1'b0;
        end else begin
            if (en && push && full) begin
                ovf <= 1'b1;
            end
            if (pop && empty) begin
                udf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ftc_tx_req.sv
module ftc_tx_req
    import ftc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] level,
    output logic          req
);

    tx_phase_e phase;

    // Armed once a load reaches the level; disarmed when the queue drains
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= TXP_FILLING;
        end else if (count >= level) begin
            phase <= TXP_ARMED;
        end else if (count == '0) begin
            phase <= TXP_FILLING;
        end
    end

    assign req = (count == '0) | ((phase == TXP_ARMED) & (count < level));

endmodule

// File: rtl/fifo_trig_ctl.sv
module fifo_trig_ctl
    import ftc_pkg::*;
#(
    parameter  int DEPTH = 128,
    parameter  int DW    = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    input  logic          feat_en,
    output logic [7:0]    cfg_rdata,
    output logic          dma_mode,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_push_data,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_pop_data,
    output logic [CW-1:0] tx_count,
    output logic          tx_full,
    output logic          tx_empty,
    output logic          tx_req,
    output logic          tx_ovf,
    output logic          tx_udf,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_push_data,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_pop_data,
    output logic [CW-1:0] rx_count,
    output logic          rx_full,
    output logic          rx_empty,
    output logic          rx_req,
    output logic          rx_ovf,
    output logic          rx_udf
);

    localparam int NSIDE   = 2;
    localparam int SIDE_TX = 0;
    localparam int SIDE_RX = 1;

    ftc_cfg_t      cfg;
    logic          tx_flush, rx_flush;
    logic [CW-1:0] tx_lvl, rx_lvl;

    logic [NSIDE-1:0] s_flush, s_push, s_pop, s_full, s_empty, s_ovf, s_udf;
    logic [DW-1:0]    s_wdata [NSIDE];
    logic [DW-1:0]    s_rdata [NSIDE];
    logic [CW-1:0]    s_count [NSIDE];

    ftc_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .feat_en  (feat_en),
        .cfg      (cfg),
        .tx_flush (tx_flush),
        .rx_flush (rx_flush),
        .rdata    (cfg_rdata)
    );

    assign dma_mode = cfg.dma;

    assign s_flush[SIDE_TX] = tx_flush;
    assign s_flush[SIDE_RX] = rx_flush;
    assign s_push[SIDE_TX]  = tx_push;
    assign s_push[SIDE_RX]  = rx_push;
    assign s_pop[SIDE_TX]   = tx_pop;
    assign s_pop[SIDE_RX]   = rx_pop;
    assign s_wdata[SIDE_TX] = tx_push_data;
    assign s_wdata[SIDE_RX] = rx_push_data;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        ftc_byte_fifo #(
            .DEPTH (DEPTH),
            .DW    (DW)
        ) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .flush     (s_flush[g]),
            .en        (cfg.en),
            .push      (s_push[g]),
            .push_data (s_wdata[g]),
            .pop       (s_pop[g]),
            .pop_data  (s_rdata[g]),
            .count     (s_count[g]),
            .full      (s_full[g]),
            .empty     (s_empty[g]),
            .ovf       (s_ovf[g]),
            .udf       (s_udf[g])
        );
    end

    assign tx_pop_data = s_rdata[SIDE_TX];
    assign tx_count    = s_count[SIDE_TX];
    assign tx_full     = s_full[SIDE_TX];
    assign tx_empty    = s_empty[SIDE_TX];
    assign tx_ovf      = s_ovf[SIDE_TX];
    assign tx_udf      = s_udf[SIDE_TX];
    assign rx_pop_data = s_rdata[SIDE_RX];
    assign rx_count    = s_count[SIDE_RX];
    assign rx_full     = s_full[SIDE_RX];
    assign rx_empty    = s_empty[SIDE_RX];
    assign rx_ovf      = s_ovf[SIDE_RX];
    assign rx_udf      = s_udf[SIDE_RX];

    assign tx_lvl = CW'(tx_level(cfg.tx_sel));
    assign rx_lvl = CW'(rx_level(cfg.rx_sel));

    ftc_tx_req #(.CW(CW)) u_txreq (
        .clk   (clk),
        .rst   (rst),
        .count (tx_count),
        .level (tx_lvl),
        .req   (tx_req)
    );

    assign rx_req = (rx_count >= rx_lvl);

endmodule

// File: rtl/ftc_chk.sv
module ftc_chk #(
    parameter  int DEPTH = 128,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic          feat_en,
    input logic          wr_tx_flush,
    input logic          wr_rx_flush,
    input logic [3:0]    trig_sel,
    input logic [1:0]    flush_bits,
    input logic          tx_push,
    input logic          tx_pop,
    input logic          tx_full,
    input logic [CW-1:0] tx_count,
    input logic          tx_req,
    input logic          tx_ovf,
    input logic          tx_udf,
    input logic          rx_pop,
    input logic          rx_empty,
    input logic [CW-1:0] rx_count,
    input logic          rx_req,
    input logic          rx_udf
);

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CW'(DEPTH) && rx_count <= CW'(DEPTH));

    // R4
    tx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        wr_tx_flush |=> tx_count == '0 && !tx_ovf && !tx_udf);

    // R5
    rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        wr_rx_flush |=> rx_count == '0 && !rx_udf);

    // R6
    flush_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        flush_bits == 2'b00);

    // R8
    trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we && !feat_en |=> trig_sel == $past(trig_sel));

    // R9
    rx_empty_noreq_chk: assert property (@(posedge clk) disable iff (rst)
        rx_count == '0 |-> !rx_req);

    // R10
    tx_empty_req_chk: assert property (@(posedge clk) disable iff (rst)
        tx_count == '0 |-> tx_req);

    // R11
    tx_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        tx_push && tx_full && !tx_pop && !wr_tx_flush |=> tx_ovf);

    // R12
    rx_udf_chk: assert property (@(posedge clk) disable iff (rst)
        rx_pop && rx_empty && !wr_rx_flush |=> rx_udf);

endmodule

bind fifo_trig_ctl ftc_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .feat_en     (feat_en),
    .wr_tx_flush (cfg_we & cfg_wdata[0] & cfg_wdata[2]),
    .wr_rx_flush (cfg_we & cfg_wdata[0] & cfg_wdata[1]),
    .trig_sel    (cfg_rdata[7:4]),
    .flush_bits  (cfg_rdata[2:1]),
    .tx_push     (tx_push),
    .tx_pop      (tx_pop),
    .tx_full     (tx_full),
    .tx_count    (tx_count),
    .tx_req      (tx_req),
    .tx_ovf      (tx_ovf),
    .tx_udf      (tx_udf),
    .rx_pop      (rx_pop),
    .rx_empty    (rx_empty),
    .rx_count    (rx_count),
    .rx_req      (rx_req),
    .rx_udf      (rx_udf)
);

// File: tb/fifo_trig_ctl_tb_top.sv
`timescale 1ns/1ps
module fifo_trig_ctl_tb_top;

    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0, feat_en = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_push_data = '0, rx_push_data = '0;
    logic [7:0] cfg_rdata, tx_pop_data, rx_pop_data, tx_count, rx_count;
    logic       dma_mode, tx_full, tx_empty, tx_req, tx_ovf, tx_udf;
    logic       rx_full, rx_empty, rx_req, rx_ovf, rx_udf;

    int   n_cmp  = 0;
    int   n_bad  = 0;
    bit   exp_en = 1'b0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #2.5 clk = ~clk;

    fifo_trig_ctl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .feat_en(feat_en), .cfg_rdata(cfg_rdata), .dma_mode(dma_mode),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_count(tx_count), .tx_full(tx_full),
        .tx_empty(tx_empty), .tx_req(tx_req), .tx_ovf(tx_ovf), .tx_udf(tx_udf),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_count(rx_count), .rx_full(rx_full),
        .rx_empty(rx_empty), .rx_req(rx_req), .rx_ovf(rx_ovf), .rx_udf(rx_udf)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic cfg(input logic [7:0] d, input logic fe);
        cfg_we = 1'b1; cfg_wdata = d; feat_en = fe;
        if (d[0] && d[2]) txq.delete();
        if (d[0] && d[1]) rxq.delete();
        exp_en = d[0];
        @(negedge clk);
        cfg_we = 1'b0; feat_en = 1'b0;
    endtask

    // driver: pushes and records what the queue must later return
    task automatic push_tx(input logic [7:0] d);
        tx_push = 1'b1; tx_push_data = d;
        if (exp_en && txq.size() < DEPTH) txq.push_back(d);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        rx_push = 1'b1; rx_push_data = d;
        if (exp_en && rxq.size() < DEPTH) rxq.push_back(d);
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // monitor side: compare head byte against the scoreboard before popping
    task automatic pop_tx();
        if (txq.size() > 0) chk("R3 tx head byte", tx_pop_data, txq.pop_front());
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic pop_rx();
        if (rxq.size() > 0) chk("R3 rx head byte", rx_pop_data, rxq.pop_front());
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_req", tx_req, 1);
        chk("R1 rx_req", rx_req, 0);
        chk("R1 dma_mode", dma_mode, 0);
        chk("R1 readback", cfg_rdata, 8'h00);

        // R2 disabled queues drop pushes
        push_tx(8'hA5);
        push_rx(8'h5A);
        chk("R2 tx_count disabled", tx_count, 0);
        chk("R2 rx_count disabled", rx_count, 0);
        cfg(8'h01, 1'b0);
        chk("R2 enable readback", cfg_rdata, 8'h01);

        // R3 ordering, R10 level 1
        push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
        chk("R3 tx_count 3", tx_count, 3);
        chk("R10 tx_req level1 count3", tx_req, 0);
        repeat (3) pop_tx();
        chk("R3 tx_empty", tx_empty, 1);

        // R10 level 32, partial load never reaches it
        cfg(8'h31, 1'b1);
        chk("R8 readback sel", cfg_rdata, 8'h31);
        for (int i = 0; i < 10; i++) push_tx(8'(8'h40 + i));
        chk("R10 short load no req", tx_req, 0);
        repeat (9) pop_tx();
        chk("R10 short load count1 no req", tx_req, 0);
        pop_tx();
        chk("R10 empty req", tx_req, 1);
        for (int i = 0; i < 32; i++) push_tx(8'(8'h60 + i));
        chk("R10 at level32 no req", tx_req, 0);
        pop_tx();
        chk("R10 below level32 req", tx_req, 1);
        cfg(8'h11, 1'b1);
        chk("R10 level8 count31 no req", tx_req, 0);
        repeat (23) pop_tx();
        chk("R10 level8 count8 no req", tx_req, 0);
        pop_tx();
        chk("R10 level8 count7 req", tx_req, 1);
        cfg(8'h21, 1'b1);
        chk("R10 level16 count7 req", tx_req, 1);
        for (int i = 0; i < 9; i++) push_tx(8'(8'h90 + i));
        chk("R10 level16 count16 no req", tx_req, 0);
        pop_tx();
        chk("R10 level16 count15 req", tx_req, 1);

        // R4 transmit flush leaves receive side alone
        push_rx(8'h71); push_rx(8'h72);
        cfg(8'h05, 1'b0);
        chk("R4 tx_count after flush", tx_count, 0);
        chk("R4 rx_count kept", rx_count, 2);
        chk("R6 flush bit reads 0, R8 sel kept", cfg_rdata, 8'h21);
        push_tx(8'h81); push_tx(8'h82);
        cfg(8'h04, 1'b0);
        chk("R4 no flush without bit0", tx_count, 2);
        chk("R2 disable readback", cfg_rdata, 8'h20);
        push_tx(8'h99);
        chk("R2 push dropped while disabled", tx_count, 2);
        cfg(8'h01, 1'b0);
        repeat (2) pop_tx();

        // R11 overflow, R12 underflow
        for (int i = 0; i < DEPTH; i++) push_tx(8'(i ^ 8'h5A));
        chk("R11 count at depth", tx_count, DEPTH);
        chk("R11 tx_full", tx_full, 1);
        chk("R11 no ovf yet", tx_ovf, 0);
        push_tx(8'hEE);
        chk("R11 tx_ovf", tx_ovf, 1);
        chk("R11 count unchanged", tx_count, DEPTH);
        for (int i = 0; i < DEPTH; i++) pop_tx();
        chk("R11 ovf sticky", tx_ovf, 1);
        chk("R12 no udf yet", tx_udf, 0);
        pop_tx();
        chk("R12 tx_udf", tx_udf, 1);
        chk("R12 count stays 0", tx_count, 0);
        cfg(8'h05, 1'b0);
        chk("R11 ovf cleared by flush", tx_ovf, 0);
        chk("R12 udf cleared by flush", tx_udf, 0);

        // R9 receive levels
        chk("R9 level1 count2 req", rx_req, 1);
        repeat (2) pop_rx();
        chk("R9 level1 count0 no req", rx_req, 0);
        cfg(8'h61, 1'b1);
        for (int i = 0; i < 15; i++) push_rx(8'(8'hB0 + i));
        chk("R9 level16 count15", rx_req, 0);
        push_rx(8'hBF);
        chk("R9 level16 count16", rx_req, 1);
        pop_rx();
        chk("R9 level16 back to 15", rx_req, 0);
        cfg(8'hA1, 1'b1);
        for (int i = 0; i < 17; i++) push_rx(8'(8'hC0 + i));
        chk("R9 level32 count32", rx_req, 1);
        pop_rx();
        chk("R9 level32 count31", rx_req, 0);
        cfg(8'hE1, 1'b1);
        for (int i = 0; i < 25; i++) push_rx(8'(8'hD0 + i));
        chk("R9 level56 count56", rx_req, 1);
        pop_rx();
        chk("R9 level56 count55", rx_req, 0);

        // R5 receive flush leaves transmit side alone
        push_tx(8'h3C);
        cfg(8'h23, 1'b0);
        chk("R5 rx_count after flush", rx_count, 0);
        chk("R5 tx_count kept", tx_count, 1);
        chk("R6 readback after rx flush", cfg_rdata, 8'hE1);
        for (int i = 0; i <= DEPTH; i++) push_rx(8'(i));
        chk("R11 rx_ovf", rx_ovf, 1);
        chk("R11 rx_full", rx_full, 1);
        cfg(8'h03, 1'b0);
        chk("R11 rx_ovf cleared", rx_ovf, 0);
        pop_rx();
        chk("R12 rx_udf", rx_udf, 1);

        // R7 mode flag
        cfg(8'h09, 1'b0);
        chk("R7 dma_mode set", dma_mode, 1);
        chk("R7 readback", cfg_rdata, 8'hE9);
        cfg(8'h01, 1'b0);
        chk("R7 dma_mode clear", dma_mode, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule